// File: doc/BRIEF.md
# Burst Beat Address and Byte-Lane Generator

This block walks through the beats of one memory-mapped burst and supplies, for every beat, the byte address, the beat number, the byte-lane offset on the data bus and the byte-enable mask. A one-cycle start pulse loads a descriptor made of the start address, the length field (beats minus one), the size field (log2 of bytes per beat) and the burst kind. One cycle after the pulse, either the first beat is presented or a one-cycle error pulse reports a descriptor that cannot be generated.

The block moves to the next beat only on a cycle where the beat is presented and the accept input is high. It flags the final beat and goes idle once that beat is accepted. Three burst kinds are supported. A fixed burst repeats its address. An incrementing burst steps by the transfer size and aligns every beat after the first. A wrapping burst stays inside a window equal to the total burst size. The total byte count of the burst is also reported. A channel controller uses the block to place narrow or unaligned transfers on a wide data bus.

Top module: `axi_beat_addr_gen`

## Requirements
- R1: A start pulse on an idle block is rejected with `err_o` high for exactly the next cycle and no beat presented when any of these holds: the kind is 3; the size field exceeds log2(BUS_BYTES); the kind is wrap (2) and the length field is not 1, 3, 7 or 15; the kind is wrap and the start address is not a multiple of 2^size.
- R2: A legal start presents beat 0 (`beat_valid_o` high, `beat_idx_o` = 0) on the next cycle. The burst has length+1 beats, numbered upward. `last_o` is high only on the final beat, and `beat_valid_o` is low on the cycle after the final beat is accepted.
- R3: For kind 0 (fixed), every beat address equals the start address.
- R4: For kind 1 (incrementing), beat 0 uses the start address. Beat i>0 uses (start + i*2^size) with the address bits below bit `size` cleared.
- R5: For kind 2 (wrap), with window W = 2^size*(length+1) and base B = start rounded down to a multiple of W, beat i uses B + ((start + i*2^size - B) mod W).
- R6: `lane_off_o` equals the beat address modulo BUS_BYTES, which is its low log2(BUS_BYTES) bits.
- R7: `strobe_o` bit j is set exactly when j >= offset and j < (offset rounded down to a multiple of 2^size) + 2^size. Bit 0 is lane 0.
- R8: While a beat is presented and `accept_i` is low, all beat outputs hold their values.
- R9: A start pulse while a burst is in progress is ignored, and the running burst continues unchanged.
- R10: From the cycle after a legal start, `total_bytes_o` equals (length+1)*2^size.
- R11: After reset the block is idle, with `beat_valid_o`, `last_o` and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load a burst descriptor (taken only when idle) |
| start_addr_i | input | ADDR_W | Start byte address |
| len_i | input | 8 | Beats minus one |
| size_i | input | 3 | log2 of bytes per beat |
| burst_i | input | 2 | 0 fixed, 1 incrementing, 2 wrap, 3 illegal |
| accept_i | input | 1 | Current beat taken this cycle |
| beat_valid_o | output | 1 | A beat is presented |
| beat_addr_o | output | ADDR_W | Address of the presented beat |
| beat_idx_o | output | 8 | Beat number, from 0 |
| lane_off_o | output | log2(BUS_BYTES) | Byte-lane offset of the beat |
| strobe_o | output | BUS_BYTES | Byte-enable mask of the beat |
| last_o | output | 1 | Final beat of the burst |
| err_o | output | 1 | Descriptor rejected (one-cycle pulse) |
| total_bytes_o | output | log2(256*BUS_BYTES)+1 | Bytes moved by the burst |

## Verification
A corrupted stored address or step shows as a wrong `beat_addr_o` and `lane_off_o` on the first beat after the bad step, so every beat of every burst is compared. A stale beat counter shows as `last_o` on the wrong beat, as a burst one beat too long or too short, or as `beat_valid_o` still high one cycle after the final accept. Stalls and start pulses during a burst are mixed in so that a state update missing its enable corrupts the very next presented beat.

// File: rtl/axi_bg_pkg.sv
// Package: shared encodings for the burst beat generator.
// Assumes: the burst kind field is two bits wide.
package axi_bg_pkg;

    typedef enum logic [1:0] {
        BK_FIXED = 2'd0,
        BK_INCR  = 2'd1,
        BK_WRAP  = 2'd2,
        BK_RSVD  = 2'd3
    } burst_kind_e;

    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;

endpackage

// File: rtl/burst_legal_chk.sv
// Module: burst_legal_chk
// Decides whether a burst descriptor can be generated. Rejects the reserved
// kind, sizes wider than the bus, wrap bursts whose beat count is not
// 2/4/8/16, and wrap bursts whose start is not size-aligned.
// Assumes: LANE_W = log2 of the data-bus width in bytes.
module burst_legal_chk
    import axi_bg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANE_W = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [1:0]        burst_i,
    output logic              bad_o
);

    logic [ADDR_W-1:0] size_mask;
    logic              wrap_len_ok;
    logic              size_ok;

    // Low-bit mask of one transfer and the individual legality terms.
    always_comb begin
        size_mask   = (ADDR_W'(1) << size_i) - ADDR_W'(1);
        wrap_len_ok = (len_i == 8'd1) || (len_i == 8'd3) ||
                      (len_i == 8'd7) || (len_i == 8'd15);
        size_ok     = ({1'b0, size_i} <= (SIZE_W+1)'(LANE_W));
    end

    // Combine the terms into one reject flag.
    always_comb begin
        bad_o = 1'b0;
        if (burst_i == BK_RSVD) bad_o = 1'b1;
        if (!size_ok)           bad_o = 1'b1;
        if (burst_i == BK_WRAP) begin
            if (!wrap_len_ok)                    bad_o = 1'b1;
            if ((addr_i & size_mask) != '0)      bad_o = 1'b1;
        end
    end

endmodule

// File: rtl/beat_addr_step.sv
// Module: beat_addr_step
// Computes the address of the next beat from the current one.
// Fixed: unchanged. Incrementing: add one transfer and clear the bits below
// the size, which aligns an unaligned first beat. Wrap: add one transfer and
// keep the bits above the window from the current address.
// Assumes: for wrap the current address is size-aligned and length+1 is a
// power of two (guaranteed by burst_legal_chk).
module beat_addr_step
    import axi_bg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [SIZE_W-1:0] size_i,
    input  burst_kind_e       kind_i,
    output logic [ADDR_W-1:0] nxt_o
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] align_mask;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] sum;

    // Transfer step, alignment mask and wrap window mask.
    always_comb begin
        step       = ADDR_W'(1) << size_i;
        align_mask = step - ADDR_W'(1);
        win_mask   = ((ADDR_W'(len_i) + ADDR_W'(1)) << size_i) - ADDR_W'(1);
        sum        = cur_i + step;
    end

    // Select the next address by burst kind.
    always_comb begin
        case (kind_i)
            BK_INCR: nxt_o = sum & ~align_mask;
            BK_WRAP: nxt_o = (cur_i & ~win_mask) | (sum & win_mask);
            default: nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/lane_strobe_gen.sv
// Module: lane_strobe_gen
// Builds the byte-enable mask of a beat: lanes from the offset up to, not
// including, the next size-aligned boundary above the offset.
// Assumes: size does not exceed LANE_W.
module lane_strobe_gen
    import axi_bg_pkg::*;
#(
    parameter int BUS_BYTES = 8,
    parameter int LANE_W    = 3
) (
    input  logic [LANE_W-1:0]    off_i,
    input  logic [SIZE_W-1:0]    size_i,
    output logic [BUS_BYTES-1:0] strobe_o
);

    logic [LANE_W:0] step;
    logic [LANE_W:0] lo;
    logic [LANE_W:0] hi_excl;

    // Lower and exclusive upper lane bounds of the payload.
    always_comb begin
        step    = (LANE_W+1)'(1) << size_i;
        lo      = {1'b0, off_i};
        hi_excl = (lo & ~(step - (LANE_W+1)'(1))) + step;
    end

    // One enable per lane.
    for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
        assign strobe_o[g] = ((LANE_W+1)'(g) >= lo) && ((LANE_W+1)'(g) < hi_excl);
    end

endmodule

// File: rtl/axi_beat_addr_gen.sv
// Module: axi_beat_addr_gen (top)
// Loads a burst descriptor on a start pulse, rejects illegal ones with a
// one-cycle error pulse, and otherwise presents one beat at a time, moving on
// when accept_i is high. Reports address, index, lane offset, byte enables,
// the last-beat flag and the total byte count.
// Assumes: BUS_BYTES is a power of two and at least 2.
module axi_beat_addr_gen
    import axi_bg_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 8,
    localparam int LANE_W   = $clog2(BUS_BYTES),
    localparam int TOT_W    = $clog2(256 * BUS_BYTES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [ADDR_W-1:0]    start_addr_i,
    input  logic [LEN_W-1:0]     len_i,
    input  logic [SIZE_W-1:0]    size_i,
    input  logic [1:0]           burst_i,
    input  logic                 accept_i,
    output logic                 beat_valid_o,
    output logic [ADDR_W-1:0]    beat_addr_o,
    output logic [LEN_W-1:0]     beat_idx_o,
    output logic [LANE_W-1:0]    lane_off_o,
    output logic [BUS_BYTES-1:0] strobe_o,
    output logic                 last_o,
    output logic                 err_o,
    output logic [TOT_W-1:0]     total_bytes_o
);

    logic              active_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic [SIZE_W-1:0] size_q;
    burst_kind_e       kind_q;
    logic              err_q;
    logic [TOT_W-1:0]  total_q;

    logic              desc_bad;
    logic [ADDR_W-1:0] addr_nxt;
    logic              take_start;
    logic              take_beat;
    logic              at_last;

    burst_legal_chk #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W)
    ) legal_i (
        .addr_i  (start_addr_i),
        .len_i   (len_i),
        .size_i  (size_i),
        .burst_i (burst_i),
        .bad_o   (desc_bad)
    );

    beat_addr_step #(
        .ADDR_W (ADDR_W)
    ) step_i (
        .cur_i  (addr_q),
        .len_i  (len_q),
        .size_i (size_q),
        .kind_i (kind_q),
        .nxt_o  (addr_nxt)
    );

    lane_strobe_gen #(
        .BUS_BYTES (BUS_BYTES),
        .LANE_W    (LANE_W)
    ) strb_i (
        .off_i    (addr_q[LANE_W-1:0]),
        .size_i   (size_q),
        .strobe_o (strobe_o)
    );

    // Handshake qualifiers.
    always_comb begin
        take_start = start_i && !active_q;
        take_beat  = active_q && accept_i;
        at_last    = (idx_q == len_q);
    end

    // Burst sequencing: load, step and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            addr_q   <= '0;
            idx_q    <= '0;
            len_q    <= '0;
            size_q   <= '0;
            kind_q   <= BK_FIXED;
        end else if (take_start && !desc_bad) begin
            active_q <= 1'b1;
            addr_q   <= start_addr_i;
            idx_q    <= '0;
            len_q    <= len_i;
            size_q   <= size_i;
            kind_q   <= burst_kind_e'(burst_i);
        end else if (take_beat) begin
            if (at_last) begin
                active_q <= 1'b0;
            end else begin
                addr_q <= addr_nxt;
                idx_q  <= idx_q + 8'd1;
            end
        end
    end

    // One-cycle reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= take_start && desc_bad;
    end

    // Total byte count of the accepted burst.
    always_ff @(posedge clk) begin
        if (!rst_n) total_q <= '0;
        else if (take_start && !desc_bad)
            total_q <= (TOT_W'(len_i) + TOT_W'(1)) << size_i;
    end

    // Output drive.
    always_comb begin
        beat_valid_o  = active_q;
        beat_addr_o   = addr_q;
        beat_idx_o    = idx_q;
        lane_off_o    = addr_q[LANE_W-1:0];
        last_o        = active_q && at_last;
        err_o         = err_q;
        total_bytes_o = total_q;
    end

endmodule

// File: rtl/axi_beat_addr_gen_chk.sv
// Module: axi_beat_addr_gen_chk
// Temporal checks on the generator ports; bound to every instance.
module axi_beat_addr_gen_chk #(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 8,
    parameter int LANE_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 accept_i,
    input logic                 beat_valid_o,
    input logic [ADDR_W-1:0]    beat_addr_o,
    input logic [7:0]           beat_idx_o,
    input logic [LANE_W-1:0]    lane_off_o,
    input logic [BUS_BYTES-1:0] strobe_o,
    input logic                 last_o,
    input logic                 err_o
);

    assert_err_no_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !beat_valid_o);

    assert_first_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid_o) |-> (beat_idx_o == 8'd0));

    assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && accept_i && !last_o) |=>
            (beat_valid_o && (beat_idx_o == 8'($past(beat_idx_o) + 8'd1))));

    assert_end_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && accept_i && last_o) |=> !beat_valid_o);

    assert_last_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_valid_o);

    assert_offset_lane_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> strobe_o[lane_off_o]);

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !accept_i) |=>
            (beat_valid_o && $stable(beat_addr_o) && $stable(beat_idx_o) &&
             $stable(strobe_o) && $stable(last_o)));

endmodule

bind axi_beat_addr_gen axi_beat_addr_gen_chk #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES),
    .LANE_W    (LANE_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept_i),
    .beat_valid_o (beat_valid_o),
    .beat_addr_o  (beat_addr_o),
    .beat_idx_o   (beat_idx_o),
    .lane_off_o   (lane_off_o),
    .strobe_o     (strobe_o),
    .last_o       (last_o),
    .err_o        (err_o)
);

// File: tb/axi_beat_addr_gen_tb_top.sv
// Bench: sweeps burst kind, size, length and start offset on a 16-bit
// address, 8-byte bus configuration; expected values are computed here.
module axi_beat_addr_gen_tb_top;

    localparam int AW = 16;
    localparam int BB = 8;
    localparam int LW = 3;
    localparam int TW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [7:0]    len_i = '0;
    logic [2:0]    size_i = '0;
    logic [1:0]    burst_i = '0;
    logic          accept_i = 1'b0;
    logic          beat_valid_o;
    logic [AW-1:0] beat_addr_o;
    logic [7:0]    beat_idx_o;
    logic [LW-1:0] lane_off_o;
    logic [BB-1:0] strobe_o;
    logic          last_o;
    logic          err_o;
    logic [TW-1:0] total_bytes_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    axi_beat_addr_gen #(.ADDR_W(AW), .BUS_BYTES(BB)) dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .start_addr_i (start_addr_i), .len_i (len_i), .size_i (size_i),
        .burst_i (burst_i), .accept_i (accept_i),
        .beat_valid_o (beat_valid_o), .beat_addr_o (beat_addr_o),
        .beat_idx_o (beat_idx_o), .lane_off_o (lane_off_o),
        .strobe_o (strobe_o), .last_o (last_o), .err_o (err_o),
        .total_bytes_o (total_bytes_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(int base, int i, int len, int sz, int kind);
        int bpb = 1 << sz;
        int win;
        int wb;
        if (kind == 0) return base;
        if (kind == 1) begin
            if (i == 0) return base;
            return ((base + i * bpb) & ~(bpb - 1)) & 16'hFFFF;
        end
        win = bpb * (len + 1);
        wb  = (base / win) * win;
        return (wb + ((base + i * bpb - wb) % win)) & 16'hFFFF;
    endfunction

    function automatic int exp_strobe(int addr, int sz);
        int off = addr % BB;
        int bpb = 1 << sz;
        int hi  = (off & ~(bpb - 1)) + bpb;
        int m   = 0;
        for (int j = 0; j < BB; j++)
            if (j >= off && j < hi) m |= (1 << j);
        return m;
    endfunction

    function automatic bit exp_bad(int base, int len, int sz, int kind);
        if (kind == 3) return 1'b1;
        if (sz > LW) return 1'b1;
        if (kind == 2) begin
            if (!(len == 1 || len == 3 || len == 7 || len == 15)) return 1'b1;
            if ((base & ((1 << sz) - 1)) != 0) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Check every output of the presented beat against the model.
    task automatic chk_beat(int base, int i, int len, int sz, int kind);
        int a = exp_addr(base, i, len, sz, kind);
        string rq = (kind == 0) ? "R3" : (kind == 1) ? "R4" : "R5";
        chk("R2 valid", int'(beat_valid_o), 1);
        chk("R2 index", int'(beat_idx_o), i);
        chk("R2 last", int'(last_o), (i == len) ? 1 : 0);
        chk({rq, " addr"}, int'(beat_addr_o), a);
        chk("R6 lane offset", int'(lane_off_o), a % BB);
        chk("R7 strobe", int'(strobe_o), exp_strobe(a, sz));
    endtask

    task automatic run_burst(int base, int len, int sz, int kind, int seed, bit poke);
        @(negedge clk);
        start_addr_i = AW'(base); len_i = 8'(len); size_i = 3'(sz); burst_i = 2'(kind);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (exp_bad(base, len, sz, kind)) begin
            chk("R1 err pulse", int'(err_o), 1);
            chk("R1 no beat", int'(beat_valid_o), 0);
            @(negedge clk);
            chk("R1 err one cycle", int'(err_o), 0);
            chk("R1 still idle", int'(beat_valid_o), 0);
            return;
        end
        chk("R1 no err", int'(err_o), 0);
        chk("R10 total", int'(total_bytes_o), (len + 1) << sz);
        for (int i = 0; i <= len; i++) begin
            chk_beat(base, i, len, sz, kind);
            if (((i + seed) % 3) == 1) begin
                accept_i = 1'b0;
                @(negedge clk);
                chk("R8 hold idx", int'(beat_idx_o), i);
                chk("R8 hold addr", int'(beat_addr_o), exp_addr(base, i, len, sz, kind));
            end
            accept_i = 1'b1;
            if (poke && i == 0) begin
                start_i = 1'b1; start_addr_i = 16'h1111; len_i = 8'd3;
                size_i = 3'd1; burst_i = 2'd1;
            end
            @(negedge clk);
            start_i = 1'b0;
            accept_i = 1'b0;
            if (poke && i == 0 && len > 0)
                chk("R9 start ignored idx", int'(beat_idx_o), 1);
        end
        chk("R2 idle after last", int'(beat_valid_o), 0);
        chk("R2 no last when idle", int'(last_o), 0);
    endtask

    // Watchdog.
    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog act=hung exp=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        int lens[6] = '{0, 1, 2, 3, 7, 15};
        repeat (3) @(negedge clk);
        chk("R11 reset valid", int'(beat_valid_o), 0);
        chk("R11 reset last", int'(last_o), 0);
        chk("R11 reset err", int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", int'(beat_valid_o), 0);
        for (int k = 0; k < 4; k++)
            for (int s = 0; s < 5; s++)
                for (int l = 0; l < 6; l++)
                    for (int o = 0; o < BB; o++)
                        run_burst(16'h0F40 | o, lens[l], s, k, k + s + l + o, o[0]);
        // Long incrementing burst up to the top of the address space.
        run_burst(16'hFF00, 255, 0, 1, 0, 1'b1);
        // Wrap with a size larger than the beat window offset.
        run_burst(16'h0F78, 15, 3, 2, 2, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule